// File: doc/BRIEF.md
# Linked-Descriptor Single-Channel DMA Engine

This block is one channel of a memory-mapped DMA controller. It copies a run of equal-sized elements between a device port that never moves and a memory buffer that advances one element per step. Four 32-bit channel registers hold the transfer:

| Word | Contents |
|------|----------|
| 0 | device address |
| 1 | memory address |
| 2 | size word: element width and element count |
| 3 | link word: chaining control and the address of the next descriptor |

A descriptor in memory has the same four words at byte offsets 0, 4, 8 and 12.

Software loads the registers, sets the direction and then writes a mode.

- **Single mode** runs the transfer that is already in the registers.
- **Chained mode** first fetches a descriptor from the address in the link register. It then keeps fetching and running descriptors until one of them ends the chain.

Every descriptor read and every data move goes through one request/acknowledge memory port.

Completion is reported as a one-cycle `done` pulse, with `err` raised alongside it for a malformed descriptor. The current activity is shown as a two-bit state code.

Top module: `dmach_engine`

## Requirements
- R1: After reset, `state` is 0 and `done`, `err` and `mem_req` are low.
- R2: The `state` output reads 0 when idle, 1 while descriptor words are being read, 2 for the single decode cycle before data starts, and 3 while elements are moving.
- R3: In chained mode each descriptor is fetched as four word reads. They go to `base`, `base+4`, `base+8` and `base+12`, in that order, and load device address, memory address, size and link. `base` is the link word with its two low bits cleared.
- R4: Size bits [13:12] select the element width. Code 3 is 1 byte, code 2 is 2 bytes and code 0 is 4 bytes. Size bits [11:0] give the element count. `mem_bytes` carries the width on data requests and 4 on descriptor reads.
- R5: A descriptor is rejected when its width code is 1, or its count exceeds 1023 for 1- or 2-byte elements, or exceeds 2047 for 4-byte elements. A rejected descriptor moves no data. It raises `done` and `err` together for one cycle and returns to idle. A count exactly at the limit is accepted.
- R6: The memory address advances by the element width after every element. The device address stays fixed.
- R7: With `dir`=1 each element is read from memory and then written to the device. With `dir`=0 it is read from the device and then written to memory.
- R8: Link bit 0 requests a `done` pulse when that descriptor finishes. In chained mode, link bit 1 set fetches the next descriptor; bit 1 clear returns to idle.
- R9: Single mode runs the register contents without any descriptor read. It always goes idle afterwards and ignores link bit 1. Mode codes: 0 off, 1 chained, 2 single.
- R10: Writing mode 0 stops the channel at once. The next cycle shows state 0, `mem_req` low and no `done`, even when the write falls on an acknowledge cycle.
- R11: A count of 0 moves no data. The descriptor still finishes through its link word.
- R12: Once raised, `mem_req`, `mem_addr` and `mem_we` hold until `mem_ack`, unless the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_we | input | 1 | channel register write strobe (idle only) |
| cfg_idx | input | 2 | register index: 0 device, 1 memory, 2 size, 3 link |
| cfg_wdata | input | 32 | register write data |
| mode_we | input | 1 | mode write strobe |
| mode_wdata | input | 2 | mode: 0 off, 1 chained, 2 single |
| dir | input | 1 | 1 memory-to-device, 0 device-to-memory |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | request is a write |
| mem_addr | output | 32 | request byte address |
| mem_wdata | output | 32 | write data, element in low bytes |
| mem_bytes | output | 3 | bytes in the request (1, 2 or 4) |
| mem_ack | input | 1 | request accepted; read data valid |
| mem_rdata | input | 32 | read data |
| state | output | 2 | activity code per R2 |
| done | output | 1 | completion pulse |
| err | output | 1 | malformed-descriptor flag, with `done` |

## Verification
A stop request can land in the same cycle that the memory acknowledges a data access. The stop must win: the acknowledged element is the last one to take effect, and neither a follow-on request nor a `done` pulse may appear. The bench waits for a strobe on the acknowledge line after a few device writes, writes mode 0 in exactly that cycle, and then compares the device write log before and after a quiet interval. It also checks the state and request lines in the next cycle. A second overlap, a `done` pulse that coincides with the fetch of the next descriptor, is judged by counting pulses over a chained run.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
   localparam int WORD_W  = 32;
   localparam int CNT_FLD = 12;
   localparam int WID_LO  = 12;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DESC = 2'd1,
      ST_WAIT = 2'd2,
      ST_ACC  = 2'd3
   } dmach_state_e;

   localparam logic [1:0] MODE_OFF = 2'd0;
   localparam logic [1:0] MODE_SG  = 2'd1;
   localparam logic [1:0] MODE_ONE = 2'd2;

   localparam int REG_DEV  = 0;
   localparam int REG_MEM  = 1;
   localparam int REG_SIZE = 2;
   localparam int REG_LINK = 3;
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
   import dmach_pkg::*;
#(
   parameter int NREGS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_idx,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              load_en,
   input  logic [1:0]        load_idx,
   input  logic [WORD_W-1:0] load_data,
   input  logic              adv_en,
   input  logic [2:0]        adv_bytes,
   output logic [WORD_W-1:0] dev_addr,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] size_word,
   output logic [WORD_W-1:0] link_word
);
   if (NREGS != 4) begin : g_bad_nregs
      $error("dmach_regs: a descriptor has exactly four words");
   end

   logic [WORD_W-1:0] r_q [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == REG_MEM) begin : g_adv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              r_q[i] <= '0;
            else if (cfg_we && cfg_idx == 2'(i))     r_q[i] <= cfg_wdata;
            else if (load_en && load_idx == 2'(i))   r_q[i] <= load_data;
            else if (adv_en)                         r_q[i] <= r_q[i] + WORD_W'(adv_bytes);
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              r_q[i] <= '0;
            else if (cfg_we && cfg_idx == 2'(i))     r_q[i] <= cfg_wdata;
            else if (load_en && load_idx == 2'(i))   r_q[i] <= load_data;
         end
      end
   end

   assign dev_addr  = r_q[REG_DEV];
   assign mem_addr  = r_q[REG_MEM];
   assign size_word = r_q[REG_SIZE];
   assign link_word = r_q[REG_LINK];
endmodule

// File: rtl/dmach_decode.sv
module dmach_decode
   import dmach_pkg::*;
#(
   parameter int MAX_NARROW = 1023,
   parameter int MAX_WIDE   = 2047
) (
   input  logic [WORD_W-1:0]  size_word,
   output logic [2:0]         elem_bytes,
   output logic [CNT_FLD-1:0] count,
   output logic               bad
);
   if (MAX_WIDE >= (1 << CNT_FLD)) begin : g_bad_wide
      $error("dmach_decode: MAX_WIDE does not fit the count field");
   end
   if (MAX_NARROW > MAX_WIDE || MAX_NARROW < 1) begin : g_bad_narrow
      $error("dmach_decode: MAX_NARROW out of range");
   end

   localparam logic [CNT_FLD-1:0] LIM_N = CNT_FLD'(MAX_NARROW);
   localparam logic [CNT_FLD-1:0] LIM_W = CNT_FLD'(MAX_WIDE);

   logic [1:0]         wcode;
   logic [CNT_FLD-1:0] lim;
   logic               size_unused;

   assign wcode       = size_word[WID_LO+1:WID_LO];
   assign count       = size_word[CNT_FLD-1:0];
   assign size_unused = ^size_word[WORD_W-1:WID_LO+2];

   always_comb begin
      elem_bytes = 3'd4;
      lim        = LIM_W;
      bad        = 1'b0;
      unique case (wcode)
         2'd3:    begin elem_bytes = 3'd1; lim = LIM_N; end
         2'd2:    begin elem_bytes = 3'd2; lim = LIM_N; end
         2'd0:    begin elem_bytes = 3'd4; lim = LIM_W; end
         default: bad = 1'b1;
      endcase
      if (count > lim) bad = 1'b1;
   end
endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
   import dmach_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_we,
   input  logic [1:0]         mode_wdata,
   input  logic               dir,
   input  logic [WORD_W-1:0]  dev_addr,
   input  logic [WORD_W-1:0]  buf_addr,
   input  logic [WORD_W-1:0]  link_word,
   input  logic [2:0]         elem_bytes,
   input  logic [CNT_FLD-1:0] count,
   input  logic               bad,
   input  logic               mem_ack,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic               load_en,
   output logic [1:0]         load_idx,
   output logic               adv_en,
   output logic               mem_req,
   output logic               mem_we,
   output logic [WORD_W-1:0]  mem_addr,
   output logic [WORD_W-1:0]  mem_wdata,
   output logic [2:0]         mem_bytes,
   output logic [1:0]         state,
   output logic               done,
   output logic               err
);
   dmach_state_e       st_q, st_n;
   logic [1:0]         idx_q, idx_n;
   logic [WORD_W-1:0]  base_q, base_n;
   logic [CNT_FLD-1:0] rem_q, rem_n;
   logic               wph_q, wph_n;
   logic               sg_q, sg_n;
   logic [WORD_W-1:0]  data_q, data_n;
   logic               done_q, done_n, err_q, err_n;
   logic               abort, end_xfer;

   assign abort = mode_we && (mode_wdata == MODE_OFF);

   always_comb begin
      st_n = st_q; idx_n = idx_q; base_n = base_q; rem_n = rem_q;
      wph_n = wph_q; sg_n = sg_q; data_n = data_q;
      done_n = 1'b0; err_n = 1'b0; load_en = 1'b0; adv_en = 1'b0;
      end_xfer = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (mode_we && mode_wdata == MODE_SG) begin
               st_n = ST_DESC; idx_n = 2'd0; sg_n = 1'b1;
               base_n = {link_word[WORD_W-1:2], 2'b00};
            end else if (mode_we && mode_wdata == MODE_ONE) begin
               st_n = ST_WAIT; sg_n = 1'b0;
            end
         end
         ST_DESC: begin
            if (mem_ack) begin
               load_en = 1'b1;
               idx_n   = idx_q + 2'd1;
               if (idx_q == 2'd3) st_n = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (bad) begin
               st_n = ST_IDLE; done_n = 1'b1; err_n = 1'b1;
            end else if (count == '0) begin
               end_xfer = 1'b1;
            end else begin
               rem_n = count; wph_n = 1'b0; st_n = ST_ACC;
            end
         end
         ST_ACC: begin
            if (mem_ack) begin
               if (!wph_q) begin
                  data_n = mem_rdata; wph_n = 1'b1;
               end else begin
                  adv_en = 1'b1; wph_n = 1'b0;
                  rem_n  = rem_q - CNT_FLD'(1);
                  if (rem_q == CNT_FLD'(1)) end_xfer = 1'b1;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
      if (end_xfer) begin
         done_n = link_word[0];
         if (sg_q && link_word[1]) begin
            st_n = ST_DESC; idx_n = 2'd0;
            base_n = {link_word[WORD_W-1:2], 2'b00};
         end else begin
            st_n = ST_IDLE;
         end
      end
      if (abort) begin
         st_n = ST_IDLE; done_n = 1'b0; err_n = 1'b0;
         load_en = 1'b0; adv_en = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; idx_q <= '0; base_q <= '0; rem_q <= '0;
         wph_q <= 1'b0; sg_q <= 1'b0; data_q <= '0;
         done_q <= 1'b0; err_q <= 1'b0;
      end else begin
         st_q <= st_n; idx_q <= idx_n; base_q <= base_n; rem_q <= rem_n;
         wph_q <= wph_n; sg_q <= sg_n; data_q <= data_n;
         done_q <= done_n; err_q <= err_n;
      end
   end

   assign load_idx  = idx_q;
   assign mem_req   = (st_q == ST_DESC) || (st_q == ST_ACC);
   assign mem_we    = (st_q == ST_ACC) && wph_q;
   assign mem_wdata = data_q;
   assign mem_bytes = (st_q == ST_DESC) ? 3'd4 : elem_bytes;
   assign state     = st_q;
   assign done      = done_q;
   assign err       = err_q;

   always_comb begin
      if (st_q == ST_DESC)  mem_addr = base_q + {28'd0, idx_q, 2'b00};
      else if (wph_q)       mem_addr = dir ? dev_addr : buf_addr;
      else                  mem_addr = dir ? buf_addr : dev_addr;
   end

   assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && state == ST_IDLE));
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (state == ST_IDLE && !done && !mem_req));
   assert_fetch_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DESC) |-> (mem_req && !mem_we && mem_addr[1:0] == 2'b00 && mem_bytes == 3'd4));
   assert_req_states_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (state == ST_DESC || state == ST_ACC));
endmodule

// File: rtl/dmach_engine.sv
module dmach_engine
   import dmach_pkg::*;
#(
   parameter int MAX_NARROW = 1023,
   parameter int MAX_WIDE   = 2047
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_idx,
   input  logic [31:0] cfg_wdata,
   input  logic        mode_we,
   input  logic [1:0]  mode_wdata,
   input  logic        dir,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   output logic [2:0]  mem_bytes,
   input  logic        mem_ack,
   input  logic [31:0] mem_rdata,
   output logic [1:0]  state,
   output logic        done,
   output logic        err
);
   logic [WORD_W-1:0]  dev_a, buf_a, size_w, link_w;
   logic               load_en, adv_en, bad;
   logic [1:0]         load_idx;
   logic [2:0]         elem_bytes;
   logic [CNT_FLD-1:0] count;

   dmach_regs u_regs (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata,
      .load_en, .load_idx, .load_data(mem_rdata),
      .adv_en, .adv_bytes(elem_bytes),
      .dev_addr(dev_a), .mem_addr(buf_a), .size_word(size_w), .link_word(link_w)
   );

   dmach_decode #(.MAX_NARROW(MAX_NARROW), .MAX_WIDE(MAX_WIDE)) u_dec (
      .size_word(size_w), .elem_bytes, .count, .bad
   );

   dmach_fsm u_fsm (
      .clk, .rst_n, .mode_we, .mode_wdata, .dir,
      .dev_addr(dev_a), .buf_addr(buf_a), .link_word(link_w),
      .elem_bytes, .count, .bad, .mem_ack, .mem_rdata,
      .load_en, .load_idx, .adv_en,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_bytes,
      .state, .done, .err
   );
endmodule

// File: tb/dmach_engine_test.sv
module dmach_engine_test;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 1'b0, mode_we = 1'b0, dir = 1'b0;
   logic [1:0]  cfg_idx = '0, mode_wdata = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req, mem_we, mem_ack, done, err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [2:0]  mem_bytes;
   logic [1:0]  state;

   int vecs = 0, miss = 0;
   bit finished = 0;

   localparam logic [31:0] DEV = 32'h8000_0040;

   dmach_engine uut (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .mode_we, .mode_wdata, .dir,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_bytes, .mem_ack, .mem_rdata,
      .state, .done, .err
   );

   always #5 clk = ~clk;

   // ---------------- memory and device model ----------------
   logic [7:0]  mem [0:2047];
   logic [31:0] dev_log [0:1023];
   logic [31:0] rd_log [0:15];
   int dev_rd_n, dev_wr_n, rd_n, wr_n, dev_addr_bad;
   logic ack_q = 1'b0;
   logic [31:0] rdata_q = '0;
   assign mem_ack   = ack_q;
   assign mem_rdata = rdata_q;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction
   function automatic logic [31:0] devval(input int k);
      return 32'hC300_0000 ^ (k * 32'h0001_0205);
   endfunction
   function automatic logic [31:0] bmask(input int b);
      return (b == 1) ? 32'hFF : (b == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction
   function automatic logic [31:0] patval(input int a, input int b);
      logic [31:0] v = '0;
      for (int j = 0; j < b; j++) v |= 32'(pat(a + j)) << (8 * j);
      return v;
   endfunction

   always @(posedge clk) begin
      if (mem_req && !ack_q) begin
         int a;
         a = int'(mem_addr[10:0]);
         ack_q <= 1'b1;
         if (mem_addr[31]) begin
            if (mem_addr != DEV) dev_addr_bad++;
            if (mem_we) begin
               if (dev_wr_n < 1024) dev_log[dev_wr_n] = mem_wdata & bmask(int'(mem_bytes));
               dev_wr_n++;
            end else begin
               rdata_q <= devval(dev_rd_n);
               dev_rd_n++;
            end
         end else if (mem_we) begin
            for (int j = 0; j < int'(mem_bytes); j++) mem[(a + j) & 2047] = mem_wdata[8*j +: 8];
            wr_n++;
         end else begin
            rdata_q <= {mem[(a+3)&2047], mem[(a+2)&2047], mem[(a+1)&2047], mem[a]};
            if (rd_n < 16) rd_log[rd_n] = mem_addr;
            rd_n++;
         end
      end else begin
         ack_q <= 1'b0;
      end
   end

   // ---------------- monitor ----------------
   int n_done, n_err, desc_state_bad, hold_bad;
   logic [3:0] seen;
   logic p_req = 0, p_ack = 0, p_abort = 0;
   logic [31:0] p_addr = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (done) n_done++;
         if (err) n_err++;
         seen[state] = 1'b1;
         if (mem_req && !mem_we && !mem_addr[31] && mem_addr >= 32'h600 && mem_addr < 32'h680 && state != 2'd1)
            desc_state_bad++;
         if (p_req && !p_ack && !p_abort && (!mem_req || mem_addr != p_addr)) hold_bad++;
      end
      p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
      p_abort = mode_we && (mode_wdata == 2'd0);
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic clr();
      dev_rd_n = 0; dev_wr_n = 0; rd_n = 0; wr_n = 0; dev_addr_bad = 0;
      n_done = 0; n_err = 0; seen = '0; desc_state_bad = 0;
      for (int i = 0; i < 2048; i++) mem[i] = pat(i);
   endtask

   task automatic put_word(input int a, input logic [31:0] w);
      for (int j = 0; j < 4; j++) mem[a + j] = w[8*j +: 8];
   endtask

   task automatic wr_reg(input int idx, input logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic load4(input logic [31:0] d, m, s, l);
      wr_reg(0, d); wr_reg(1, m); wr_reg(2, s); wr_reg(3, l);
   endtask

   task automatic run(input logic [1:0] m);
      int n = 0;
      @(negedge clk); mode_we = 1'b1; mode_wdata = m;
      @(negedge clk); mode_we = 1'b0;
      while (state != 2'd0 && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) begin
         miss++; vecs++;
         $display("FAIL run timeout act=%0d exp=0", state);
      end
      repeat (2) @(negedge clk);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      clr();
      repeat (3) @(negedge clk);
      chk("R1 state", 32'(state), 0);
      chk("R1 done/err/req", {29'd0, done, err, mem_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // single-mode sweep: width x direction x count   (R4 R6 R7 R9)
      for (int wi = 0; wi < 3; wi++) begin
         for (int d = 0; d < 2; d++) begin
            for (int ci = 0; ci < 3; ci++) begin
               int b, cnt, wc;
               wc  = (wi == 0) ? 3 : (wi == 1) ? 2 : 0;
               b   = (wi == 0) ? 1 : (wi == 1) ? 2 : 4;
               cnt = (ci == 0) ? 1 : (ci == 1) ? 2 : 5;
               clr();
               dir = d[0];
               load4(DEV, 32'h100, 32'((wc << 12) | cnt), 32'h1);
               run(2'd2);
               chk("R9 done", 32'(n_done), 1);
               chk("R5 no err", 32'(n_err), 0);
               chk("R6 dev fixed", 32'(dev_addr_bad), 0);
               if (d == 1) begin
                  chk("R7 dev writes", 32'(dev_wr_n), 32'(cnt));
                  for (int k = 0; k < cnt; k++)
                     chk("R4 R6 R7 mem->dev", dev_log[k], patval(32'h100 + k * b, b));
               end else begin
                  chk("R7 dev reads", 32'(dev_rd_n), 32'(cnt));
                  for (int k = 0; k < cnt; k++)
                     chk("R4 R6 R7 dev->mem", patval(0, 0) | {mem[(32'h100+k*b+3)&2047], mem[(32'h100+k*b+2)&2047],
                         mem[(32'h100+k*b+1)&2047], mem[32'h100+k*b]} & bmask(b), devval(k) & bmask(b));
                  chk("R6 guard byte", 32'(mem[32'h100 + cnt * b]), 32'(pat(32'h100 + cnt * b)));
               end
            end
         end
      end

      // chained run, link low bits ignored for the base (R2 R3 R8)
      clr(); dir = 1'b1;
      put_word(32'h600, DEV); put_word(32'h604, 32'h200); put_word(32'h608, 32'h3004); put_word(32'h60C, 32'h612);
      put_word(32'h610, DEV); put_word(32'h614, 32'h300); put_word(32'h618, 32'h0003); put_word(32'h61C, 32'h623);
      put_word(32'h620, DEV); put_word(32'h624, 32'h380); put_word(32'h628, 32'h2002); put_word(32'h62C, 32'h000);
      load4(32'h0, 32'h0, 32'h0, 32'h602);
      run(2'd1);
      for (int i = 0; i < 4; i++) chk("R3 fetch order", rd_log[i], 32'h600 + 4 * i);
      chk("R3 second desc", rd_log[8], 32'h610);
      chk("R8 dev writes", 32'(dev_wr_n), 9);
      for (int k = 0; k < 4; k++) chk("R8 R4 d0", dev_log[k], patval(32'h200 + k, 1));
      for (int k = 0; k < 3; k++) chk("R8 R4 d1", dev_log[4 + k], patval(32'h300 + 4 * k, 4));
      for (int k = 0; k < 2; k++) chk("R8 R4 d2", dev_log[7 + k], patval(32'h380 + 2 * k, 2));
      chk("R8 done pulses", 32'(n_done), 1);
      chk("R2 all states seen", 32'(seen), 32'hF);
      chk("R2 desc state", 32'(desc_state_bad), 0);

      // chained error in mid chain (R5 R8)
      clr(); dir = 1'b1;
      put_word(32'h640, DEV); put_word(32'h644, 32'h200); put_word(32'h648, 32'h3002); put_word(32'h64C, 32'h653);
      put_word(32'h650, DEV); put_word(32'h654, 32'h200); put_word(32'h658, 32'h1002); put_word(32'h65C, 32'h001);
      load4(32'h0, 32'h0, 32'h0, 32'h640);
      run(2'd1);
      chk("R5 chain err", 32'(n_err), 1);
      chk("R8 R5 chain done", 32'(n_done), 2);
      chk("R5 chain data stops", 32'(dev_wr_n), 2);

      // single mode ignores follow bit (R9)
      clr(); dir = 1'b1;
      load4(DEV, 32'h100, 32'h3002, 32'h603);
      run(2'd2);
      chk("R9 no fetch", 32'(rd_n), 2);
      chk("R9 done", 32'(n_done), 1);
      chk("R9 idle", 32'(state), 0);

      // malformed descriptors (R5)
      for (int i = 0; i < 4; i++) begin
         logic [31:0] s;
         s = (i == 0) ? 32'h3400 : (i == 1) ? 32'h2400 : (i == 2) ? 32'h0800 : 32'h1005;
         clr(); dir = 1'b0;
         load4(DEV, 32'h100, s, 32'h0);
         run(2'd2);
         chk("R5 err", 32'(n_err), 1);
         chk("R5 done", 32'(n_done), 1);
         chk("R5 no access", 32'(dev_rd_n + dev_wr_n + rd_n + wr_n), 0);
      end

      // limit count accepted (R5)
      begin
         int bad_b = 0;
         clr(); dir = 1'b0;
         load4(DEV, 32'h100, 32'h33FF, 32'h1);
         run(2'd2);
         for (int k = 0; k < 1023; k++) if (mem[32'h100 + k] !== devval(k)[7:0]) bad_b++;
         chk("R5 limit bytes", 32'(bad_b), 0);
         chk("R5 limit no err", 32'(n_err), 0);
         chk("R5 limit done", 32'(n_done), 1);
      end

      // zero count (R11)
      clr(); dir = 1'b1;
      load4(DEV, 32'h100, 32'h0000, 32'h1);
      run(2'd2);
      chk("R11 no data", 32'(dev_rd_n + dev_wr_n + rd_n + wr_n), 0);
      chk("R11 done", 32'(n_done), 1);

      // stop coinciding with an acknowledge (R10)
      begin
         int n0, n = 0;
         clr(); dir = 1'b1;
         load4(DEV, 32'h100, 32'h30C8, 32'h1);
         @(negedge clk); mode_we = 1'b1; mode_wdata = 2'd2;
         @(negedge clk); mode_we = 1'b0;
         while (!(mem_ack && dev_wr_n >= 5) && n < 1000) begin @(negedge clk); n++; end
         mode_we = 1'b1; mode_wdata = 2'd0;
         n0 = dev_wr_n;
         @(negedge clk); mode_we = 1'b0;
         chk("R10 idle next", 32'(state), 0);
         chk("R10 req low", 32'(mem_req), 0);
         repeat (20) @(negedge clk);
         chk("R10 no more writes", 32'(dev_wr_n), 32'(n0));
         chk("R10 no done", 32'(n_done), 0);
      end

      chk("R12 request held", 32'(hold_bad), 0);

      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!finished) begin
         finished = 1;
         miss++; vecs++;
         $display("FAIL watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end
endmodule